// File: doc/BRIEF.md
# Hardware-Sequenced Serial Flash Cycle Engine

This block lets a host move data to and from a serial NOR flash without building command bytes in software. The host programs a 25-bit linear flash address, loads a 64-byte data buffer when it wants to program, and writes a control word holding a cycle code, a byte count minus one and a go bit. The engine then drives a single chip select and a mode-0 SPI bus through the full command sequence. For a program or erase, that sequence includes the write-enable frame and polling of the flash busy flag. Completion and failure appear as sticky status bits that the host clears by writing ones.

Requests that cannot be honoured are refused before any bus activity. These are a reserved cycle code, or a read or program that would run past the end of a 256-byte page. A refused request raises the error flag. A new go while a cycle is running is discarded, and the control fields keep their old values.

The state machine walks through these states:
- `ST_IDLE`: waits for go.
- `ST_WREN`: sends the write-enable frame.
- `ST_WREN_GAP`: deselects the flash for one cycle.
- `ST_CMD`: sends the opcode.
- `ST_ADDR`: sends three address bytes.
- `ST_DATA`: moves the payload.
- `ST_POLL_GAP`: deselects the flash.
- `ST_POLL_CMD`: sends the status-read opcode.
- `ST_POLL_RD`: receives the flash status byte.
- `ST_FINISH`: raises done.

The transitions are:
- `ST_IDLE`→`ST_CMD` for a read.
- `ST_IDLE`→`ST_WREN` for a program or erase.
- `ST_IDLE`→`ST_IDLE`, raising error, for a refused request.
- `ST_WREN`→`ST_WREN_GAP`→`ST_CMD`→`ST_ADDR`.
- `ST_ADDR`→`ST_DATA` for a read or program.
- `ST_ADDR`→`ST_POLL_GAP` for an erase.
- `ST_DATA`→`ST_FINISH` for a read.
- `ST_DATA`→`ST_POLL_GAP` for a program.
- `ST_POLL_GAP`→`ST_POLL_CMD`→`ST_POLL_RD`.
- `ST_POLL_RD`→`ST_POLL_GAP` while the flash reports busy.
- `ST_POLL_RD`→`ST_FINISH` once it reports idle.
- `ST_FINISH`→`ST_IDLE`.

Top module: `hwseq_flash_engine`

## Requirements
- R1: After reset the status word (register index 0) reads zero except bits 4:3, which hold the erase-size code (default 1, giving 0x0008). Chip select is high and the serial clock is low.
- R2: The address register (index 2) stores bits 24:0 of a write. Bits 31:25 always read zero.
- R3: The data buffer occupies register indices 16 to 31. Buffer byte i is held in word i/4 at bits 8*(i mod 4)+7 down to 8*(i mod 4). Payload byte i goes to or comes from flash address base+i.
- R4: Cycle code 0 (read) produces one frame: 0x03, address bits 23:0 most significant byte first, then count+1 received bytes stored in the buffer.
- R5: Cycle code 2 (program) produces two frames. The first carries 0x06 alone. The second carries 0x02, the address, and count+1 bytes taken from the buffer.
- R6: Cycle code 3 (erase) produces a 0x06 frame, then a frame with the erase opcode and the address. The erase opcode is 0xD8 when the erase-size code is 3 and 0x20 otherwise.
- R7: After a program or erase, the engine sends 0x05 frames, one status byte each, until bit 0 of that byte is 0. Only then does it set done (status bit 0). Done never rises while a cycle is in progress.
- R8: Status bits 0 (done), 1 (error) and 2 (access-error log) clear only when a one is written to them. Writing zero leaves them unchanged.
- R9: A go with cycle code 1, or a read or program where address bits 7:0 plus the count exceed 255, sets error (bit 1) and produces no frame. A request that ends exactly at the page end runs normally.
- R10: While a cycle is running, status bit 5 reads one and chip select is only low then. A control write during that time changes neither the control fields nor the bus activity.
- R11: The bus uses SPI mode 0. The clock idles low whenever chip select is high, and the data-out line stays stable while the clock is high.
- R12: The control register (index 1) reads back bit 15 (interrupt-enable flag), bits 13:8 (count minus one) and bits 2:1 (cycle code) as last accepted. Bit 0 (go) reads zero, and a control write with go clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (5) | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The hardest situation to reach from the ports is the busy-poll loop running more than once. That requires a flash that answers 0x05 with its busy bit set for several frames after a program or erase. The bench therefore carries a behavioural flash that decodes frames, honours write-enable, and reports busy for two status reads after each accepted program or erase. A go issued in the middle of a running read is the second hard case. The bench issues it straight after launching a short read, then checks the frame log and the control readback.

// File: rtl/hwseq_pkg.sv
package hwseq_pkg;

    typedef enum logic [1:0] {
        CYC_READ  = 2'd0,
        CYC_RSVD  = 2'd1,
        CYC_WRITE = 2'd2,
        CYC_ERASE = 2'd3
    } cyc_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WREN,
        ST_WREN_GAP,
        ST_CMD,
        ST_ADDR,
        ST_DATA,
        ST_POLL_GAP,
        ST_POLL_CMD,
        ST_POLL_RD,
        ST_FINISH
    } seq_st_t;

    localparam logic [7:0] OP_READ        = 8'h03;
    localparam logic [7:0] OP_WREN        = 8'h06;
    localparam logic [7:0] OP_PROG        = 8'h02;
    localparam logic [7:0] OP_RDSR        = 8'h05;
    localparam logic [7:0] OP_ERASE_SMALL = 8'h20;
    localparam logic [7:0] OP_ERASE_LARGE = 8'hD8;

    localparam int REG_STATUS = 0;
    localparam int REG_CTRL   = 1;
    localparam int REG_ADDR   = 2;

endpackage

// File: rtl/hwseq_spi_byte.sv
// One-byte full-duplex shifter, SPI mode 0. Each clock phase lasts DIV core cycles.
module hwseq_spi_byte #(
    parameter int DIV = 2,
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx
);

    logic          active_q;
    logic [2:0]    bit_q;
    logic [DW-1:0] div_q;
    logic [7:0]    txs_q;
    logic          phase_end;

    assign phase_end = (div_q == DW'(DIV - 1));
    assign mosi      = txs_q[7];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            bit_q    <= '0;
            div_q    <= '0;
            txs_q    <= '0;
            sck      <= 1'b0;
            done     <= 1'b0;
            rx       <= '0;
        end else begin
            done <= 1'b0;
            if (!active_q) begin
                if (go) begin
                    active_q <= 1'b1;
                    txs_q    <= tx;
                    bit_q    <= '0;
                    div_q    <= '0;
                    sck      <= 1'b0;
                end
            end else if (phase_end) begin
                div_q <= '0;
                if (!sck) begin
                    sck <= 1'b1;
                    rx  <= {rx[6:0], miso};
                end else begin
                    sck <= 1'b0;
                    if (bit_q == 3'd7) begin
                        active_q <= 1'b0;
                        done     <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                        txs_q <= {txs_q[6:0], 1'b0};
                    end
                end
            end else begin
                div_q <= div_q + DW'(1);
            end
        end
    end

endmodule

// File: rtl/hwseq_databuf.sv
// Word-wide host port and byte-wide engine port onto the same storage.
module hwseq_databuf #(
    parameter int WORDS = 16,
    localparam int WIDX_W = $clog2(WORDS),
    localparam int BIDX_W = WIDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_we,
    input  logic [WIDX_W-1:0] h_idx,
    input  logic [31:0]       h_wdata,
    output logic [31:0]       h_rdata,
    input  logic              e_we,
    input  logic [BIDX_W-1:0] e_bidx,
    input  logic [7:0]        e_wbyte,
    output logic [7:0]        e_rbyte
);

    logic [31:0] words [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [31:0] word_q;
        logic        host_hit;
        logic        eng_hit;

        assign host_hit = h_we && (h_idx == WIDX_W'(w));
        assign eng_hit  = e_we && (e_bidx[BIDX_W-1:2] == WIDX_W'(w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else begin
                if (host_hit) word_q <= h_wdata;
                if (eng_hit)  word_q[8*e_bidx[1:0] +: 8] <= e_wbyte;
            end
        end

        assign words[w] = word_q;
    end

    logic [31:0] eng_word;
    assign eng_word = words[e_bidx[BIDX_W-1:2]];
    assign e_rbyte  = eng_word[8*e_bidx[1:0] +: 8];
    assign h_rdata  = words[h_idx];

endmodule

// File: rtl/hwseq_seq.sv
// Cycle sequencer: builds the frame sequence for read, program and erase.
module hwseq_seq
    import hwseq_pkg::*;
#(
    parameter int         CNT_W      = 6,
    parameter logic [1:0] ERASE_CODE = 2'd1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  cyc_t             cyc_in,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic [23:0]      addr_in,
    output logic             sh_go,
    output logic [7:0]       sh_tx,
    input  logic             sh_done,
    input  logic [7:0]       sh_rx,
    output logic [CNT_W-1:0] buf_bidx,
    output logic             buf_we,
    output logic [7:0]       buf_wbyte,
    input  logic [7:0]       buf_rbyte,
    output logic             cs_n,
    output logic             busy,
    output logic             set_done,
    output logic             set_err
);

    localparam logic [7:0] ERASE_OP = (ERASE_CODE == 2'd3) ? OP_ERASE_LARGE : OP_ERASE_SMALL;

    seq_st_t          state_q, state_d;
    cyc_t             type_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] idx_q;
    logic [23:0]      addr_q;
    logic [1:0]       ab_q;
    logic             launched_q;

    logic [8:0] span;
    logic       bad_req;
    logic       byte_state;

    assign span    = {1'b0, addr_in[7:0]} + 9'(cnt_in);
    assign bad_req = (cyc_in == CYC_RSVD) || ((cyc_in != CYC_ERASE) && span[8]);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start && !bad_req)
                    state_d = (cyc_in == CYC_READ) ? ST_CMD : ST_WREN;
            end
            ST_WREN:     if (sh_done) state_d = ST_WREN_GAP;
            ST_WREN_GAP: state_d = ST_CMD;
            ST_CMD:      if (sh_done) state_d = ST_ADDR;
            ST_ADDR: begin
                if (sh_done && ab_q == 2'd2)
                    state_d = (type_q == CYC_ERASE) ? ST_POLL_GAP : ST_DATA;
            end
            ST_DATA: begin
                if (sh_done && idx_q == cnt_q)
                    state_d = (type_q == CYC_READ) ? ST_FINISH : ST_POLL_GAP;
            end
            ST_POLL_GAP: state_d = ST_POLL_CMD;
            ST_POLL_CMD: if (sh_done) state_d = ST_POLL_RD;
            ST_POLL_RD: begin
                if (sh_done) state_d = sh_rx[0] ? ST_POLL_GAP : ST_FINISH;
            end
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register and cycle context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            type_q     <= CYC_READ;
            cnt_q      <= '0;
            idx_q      <= '0;
            addr_q     <= '0;
            ab_q       <= '0;
            launched_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start && !bad_req) begin
                type_q <= cyc_in;
                cnt_q  <= cnt_in;
                addr_q <= addr_in;
                idx_q  <= '0;
                ab_q   <= '0;
            end
            if (sh_go)
                launched_q <= 1'b1;
            else if (sh_done)
                launched_q <= 1'b0;
            if (sh_done && state_q == ST_ADDR) ab_q  <= ab_q + 2'd1;
            if (sh_done && state_q == ST_DATA) idx_q <= idx_q + CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        byte_state = 1'b0;
        sh_tx      = 8'h00;
        unique case (state_q)
            ST_WREN: begin
                byte_state = 1'b1;
                sh_tx      = OP_WREN;
            end
            ST_CMD: begin
                byte_state = 1'b1;
                unique case (type_q)
                    CYC_WRITE: sh_tx = OP_PROG;
                    CYC_ERASE: sh_tx = ERASE_OP;
                    default:   sh_tx = OP_READ;
                endcase
            end
            ST_ADDR: begin
                byte_state = 1'b1;
                unique case (ab_q)
                    2'd0:    sh_tx = addr_q[23:16];
                    2'd1:    sh_tx = addr_q[15:8];
                    default: sh_tx = addr_q[7:0];
                endcase
            end
            ST_DATA: begin
                byte_state = 1'b1;
                sh_tx      = (type_q == CYC_WRITE) ? buf_rbyte : 8'h00;
            end
            ST_POLL_CMD: begin
                byte_state = 1'b1;
                sh_tx      = OP_RDSR;
            end
            ST_POLL_RD: begin
                byte_state = 1'b1;
            end
            default: begin
                byte_state = 1'b0;
            end
        endcase
    end

    assign sh_go     = byte_state && !launched_q;
    assign cs_n      = !byte_state;
    assign busy      = (state_q != ST_IDLE);
    assign set_done  = (state_q == ST_FINISH);
    assign set_err   = (state_q == ST_IDLE) && start && bad_req;
    assign buf_bidx  = idx_q;
    assign buf_we    = (state_q == ST_DATA) && (type_q == CYC_READ) && sh_done;
    assign buf_wbyte = sh_rx;

endmodule

// File: rtl/hwseq_flash_engine.sv
// Register front end of the flash cycle engine.
module hwseq_flash_engine
    import hwseq_pkg::*;
#(
    parameter int         CLK_DIV    = 2,
    parameter logic [1:0] ERASE_CODE = 2'd1,
    parameter int         BUF_WORDS  = 16,
    parameter int         ADDR_BITS  = 25,
    localparam int        WIDX_W     = $clog2(BUF_WORDS),
    localparam int        REG_AW     = WIDX_W + 1,
    localparam int        CNT_W      = WIDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    logic                 done_q, err_q;
    cyc_t                 ctrl_type_q;
    logic [CNT_W-1:0]     ctrl_cnt_q;
    logic                 ctrl_smi_q;
    logic [ADDR_BITS-1:0] faddr_q;

    logic busy, seq_set_done, seq_set_err;
    logic sel_buf, wr_status, wr_ctrl, wr_addr, start;

    assign sel_buf   = reg_addr[REG_AW-1];
    assign wr_status = reg_wr && (reg_addr == REG_AW'(REG_STATUS));
    assign wr_ctrl   = reg_wr && (reg_addr == REG_AW'(REG_CTRL));
    assign wr_addr   = reg_wr && (reg_addr == REG_AW'(REG_ADDR));
    assign start     = wr_ctrl && reg_wdata[0] && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q      <= 1'b0;
            err_q       <= 1'b0;
            ctrl_type_q <= CYC_READ;
            ctrl_cnt_q  <= '0;
            ctrl_smi_q  <= 1'b0;
            faddr_q     <= '0;
        end else begin
            if (seq_set_done)                    done_q <= 1'b1;
            else if (wr_status && reg_wdata[0])  done_q <= 1'b0;
            if (seq_set_err)                     err_q  <= 1'b1;
            else if (wr_status && reg_wdata[1])  err_q  <= 1'b0;
            if (wr_ctrl && !busy) begin
                ctrl_type_q <= cyc_t'(reg_wdata[2:1]);
                ctrl_cnt_q  <= reg_wdata[8 +: CNT_W];
                ctrl_smi_q  <= reg_wdata[15];
            end
            if (wr_addr) faddr_q <= reg_wdata[ADDR_BITS-1:0];
        end
    end

    logic             sh_go, sh_done;
    logic [7:0]       sh_tx, sh_rx;
    logic [CNT_W-1:0] buf_bidx;
    logic             buf_we;
    logic [7:0]       buf_wbyte, buf_rbyte;
    logic [31:0]      buf_rdata;

    hwseq_seq #(.CNT_W(CNT_W), .ERASE_CODE(ERASE_CODE)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cyc_in    (cyc_t'(reg_wdata[2:1])),
        .cnt_in    (reg_wdata[8 +: CNT_W]),
        .addr_in   (faddr_q[23:0]),
        .sh_go     (sh_go),
        .sh_tx     (sh_tx),
        .sh_done   (sh_done),
        .sh_rx     (sh_rx),
        .buf_bidx  (buf_bidx),
        .buf_we    (buf_we),
        .buf_wbyte (buf_wbyte),
        .buf_rbyte (buf_rbyte),
        .cs_n      (spi_cs_n),
        .busy      (busy),
        .set_done  (seq_set_done),
        .set_err   (seq_set_err)
    );

    hwseq_spi_byte #(.DIV(CLK_DIV)) shift_i (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (sh_go),
        .tx    (sh_tx),
        .miso  (spi_miso),
        .sck   (spi_sck),
        .mosi  (spi_mosi),
        .done  (sh_done),
        .rx    (sh_rx)
    );

    hwseq_databuf #(.WORDS(BUF_WORDS)) buf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .h_we    (reg_wr && sel_buf),
        .h_idx   (reg_addr[WIDX_W-1:0]),
        .h_wdata (reg_wdata),
        .h_rdata (buf_rdata),
        .e_we    (buf_we),
        .e_bidx  (buf_bidx),
        .e_wbyte (buf_wbyte),
        .e_rbyte (buf_rbyte)
    );

    logic [15:0] status_word, ctrl_word;
    assign status_word = {10'b0, busy, ERASE_CODE, 1'b0, err_q, done_q};
    assign ctrl_word   = {ctrl_smi_q, 1'b0, ctrl_cnt_q, 5'b0, ctrl_type_q, 1'b0};

    always_comb begin
        reg_rdata = '0;
        if (sel_buf)                                reg_rdata = buf_rdata;
        else if (reg_addr == REG_AW'(REG_STATUS))   reg_rdata = {16'b0, status_word};
        else if (reg_addr == REG_AW'(REG_CTRL))     reg_rdata = {16'b0, ctrl_word};
        else if (reg_addr == REG_AW'(REG_ADDR))     reg_rdata = 32'(faddr_q);
    end

endmodule

// File: rtl/hwseq_flash_engine_chk.sv
module hwseq_flash_engine_chk #(
    parameter int REG_AW = 5,
    parameter int CW     = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sck,
    input logic              cs_n,
    input logic              mosi,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic              wdata0,
    input logic              busy,
    input logic              done_q,
    input logic              set_done,
    input logic [CW-1:0]     ctrl_q
);

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);  // R11

    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));  // R11

    AST_CS_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);  // R10

    AST_DONE_AFTER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> !busy);  // R7

    AST_DONE_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == '0 && wdata0 && !set_done) |=> !done_q);  // R8

    AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == REG_AW'(1)) |=> $stable(ctrl_q));  // R10

endmodule

bind hwseq_flash_engine hwseq_flash_engine_chk #(.REG_AW(REG_AW), .CW(CNT_W + 3)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (spi_sck),
    .cs_n     (spi_cs_n),
    .mosi     (spi_mosi),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .wdata0   (reg_wdata[0]),
    .busy     (busy),
    .done_q   (done_q),
    .set_done (seq_set_done),
    .ctrl_q   ({ctrl_smi_q, ctrl_cnt_q, ctrl_type_q})
);

// File: tb/hwseq_flash_engine_tb_top.sv
`timescale 1ns/1ps
module hwseq_flash_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_cs_n, spi_mosi;
    logic        miso_r = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    hwseq_flash_engine dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .spi_sck   (spi_sck),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (miso_r)
    );

    // ---------------- behavioural flash ----------------
    logic [7:0]  mem [0:1023];
    logic [7:0]  op_log [0:255];
    int          op_n = 0;
    int          bytecnt = 0;
    int          bitc = 0;
    int          busy_left = 0;
    logic        wel = 1'b0;
    logic        load = 1'b0;
    logic [7:0]  sh_in = '0;
    logic [7:0]  frame_cmd = '0;
    logic [7:0]  next_out = '0;
    logic [7:0]  osh = '0;
    logic [23:0] maddr = '0;

    always_comb miso_r = osh[7];

    always @(negedge spi_cs_n) begin
        bytecnt = 0;
        bitc    = 0;
        osh     = 8'h00;
        load    = 1'b0;
    end

    always @(posedge spi_cs_n) begin
        if (frame_cmd == 8'h06 && bytecnt == 1) begin
            wel = 1'b1;
        end else if (frame_cmd == 8'h02 && bytecnt >= 5 && wel) begin
            busy_left = 2;
            wel = 1'b0;
        end else if ((frame_cmd == 8'h20 || frame_cmd == 8'hD8) && bytecnt == 4 && wel) begin
            for (int i = 0; i < 1024; i++)
                if (maddr[23:12] == 12'(i >> 12)) mem[i] = 8'hFF;
            busy_left = 2;
            wel = 1'b0;
        end else if (frame_cmd == 8'h05 && busy_left > 0) begin
            busy_left = busy_left - 1;
        end
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            sh_in = {sh_in[6:0], spi_mosi};
            bitc  = bitc + 1;
            if (bitc == 8) begin
                bitc = 0;
                if (bytecnt == 0) begin
                    frame_cmd = sh_in;
                    op_log[op_n[7:0]] = sh_in;
                    op_n = op_n + 1;
                end else if (bytecnt <= 3) begin
                    maddr = {maddr[15:0], sh_in};
                end else if (frame_cmd == 8'h02 && wel) begin
                    mem[maddr[9:0]] = mem[maddr[9:0]] & sh_in;
                    maddr = maddr + 24'd1;
                end else if (frame_cmd == 8'h03) begin
                    maddr = maddr + 24'd1;
                end
                bytecnt = bytecnt + 1;
                if (frame_cmd == 8'h05)
                    next_out = {7'b0, busy_left > 0};
                else if (frame_cmd == 8'h03 && bytecnt >= 4)
                    next_out = mem[maddr[9:0]];
                else
                    next_out = 8'h00;
                load = 1'b1;
            end
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n) begin
            if (load) begin
                osh  = next_out;
                load = 1'b0;
            end else begin
                osh = {osh[6:0], 1'b0};
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_end(output logic [31:0] s);
        s = '0;
        for (int i = 0; i < 20000; i++) begin
            rd(5'd0, s);
            if (s[1:0] != 2'b00) break;
        end
    endtask

    function automatic logic [31:0] ctrl(input int cnt, input int typ, input bit go);
        return (32'(cnt) << 8) | (32'(typ) << 1) | 32'(go);
    endfunction

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [31:0] s;
        rd(5'd0, s);
        check(s == 32'h8, "R1 status", s, 32'h8);
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 R11 bus idle", {spi_cs_n, spi_sck}, 32'h2);
    endtask

    task automatic t_addr();
        logic [31:0] v;
        wr(5'd2, 32'hFFFF_FFFF);
        rd(5'd2, v);
        check(v == 32'h01FF_FFFF, "R2 addr mask", v, 32'h01FF_FFFF);
    endtask

    task automatic t_ctrl_readback();
        logic [31:0] v;
        int n0 = op_n;
        wr(5'd1, 32'h8504);
        rd(5'd1, v);
        check(v == 32'h8504, "R12 ctrl readback", v, 32'h8504);
        repeat (20) @(negedge clk);
        rd(5'd0, v);
        check(op_n == n0 && v[5] == 1'b0 && v[0] == 1'b0, "R12 no start without go", v, 32'h8);
    endtask

    task automatic t_program();
        logic [31:0] s;
        int n0;
        wr(5'd16, 32'hA3A2_A1A0);
        wr(5'd17, 32'hA7A6_A5A4);
        wr(5'd2, 32'h0000_0010);
        n0 = op_n;
        wr(5'd1, ctrl(7, 2, 1'b1));
        wait_end(s);
        check(s[1:0] == 2'b01, "R7 program done", s, 32'h9);
        for (int i = 0; i < 8; i++)
            check(mem[16 + i] == 8'(8'hA0 + i), "R3 R5 program byte", 32'(mem[16 + i]), 32'(8'hA0 + i));
        check(op_n - n0 == 5, "R7 frame count", 32'(op_n - n0), 32'd5);
        check(op_log[n0[7:0]] == 8'h06 && op_log[8'(n0 + 1)] == 8'h02, "R5 opcodes",
              {op_log[n0[7:0]], op_log[8'(n0 + 1)]}, 32'h0602);
        check(op_log[8'(n0 + 2)] == 8'h05 && op_log[8'(n0 + 4)] == 8'h05, "R7 poll opcodes",
              {op_log[8'(n0 + 2)], op_log[8'(n0 + 4)]}, 32'h0505);
    endtask

    task automatic t_w1c();
        logic [31:0] s;
        wr(5'd0, 32'h0);
        rd(5'd0, s);
        check(s[0] == 1'b1, "R8 zero write keeps done", s, 32'h9);
        wr(5'd0, 32'h1);
        rd(5'd0, s);
        check(s == 32'h8, "R8 done cleared", s, 32'h8);
    endtask

    task automatic t_read_small();
        logic [31:0] s, w0, w1;
        int n0;
        wr(5'd16, 32'h0);
        wr(5'd17, 32'h0);
        wr(5'd2, 32'h0000_0010);
        n0 = op_n;
        wr(5'd1, ctrl(7, 0, 1'b1));
        wait_end(s);
        rd(5'd16, w0);
        rd(5'd17, w1);
        check(w0 == 32'hA3A2_A1A0 && w1 == 32'hA7A6_A5A4, "R4 R3 read data", w0, 32'hA3A2_A1A0);
        check(op_n - n0 == 1 && op_log[n0[7:0]] == 8'h03, "R4 read opcode",
              32'(op_log[n0[7:0]]), 32'h03);
        wr(5'd0, 32'h3);
    endtask

    task automatic t_read_full();
        logic [31:0] s, w;
        logic [31:0] exp;
        wr(5'd2, 32'h0000_0100);
        wr(5'd1, ctrl(63, 0, 1'b1));
        wait_end(s);
        check(s[1:0] == 2'b01, "R4 full read done", s, 32'h9);
        rd(5'd31, w);
        exp = {8'(63) ^ 8'h5A, 8'(62) ^ 8'h5A, 8'(61) ^ 8'h5A, 8'(60) ^ 8'h5A};
        check(w == exp, "R3 last buffer word", w, exp);
        wr(5'd0, 32'h3);
    endtask

    task automatic t_page_edge();
        logic [31:0] s, w;
        int n0;
        wr(5'd2, 32'h0000_00F8);
        wr(5'd1, ctrl(7, 0, 1'b1));
        wait_end(s);
        rd(5'd17, w);
        check(s[1:0] == 2'b01 && w == 32'hC7C6_C5C4, "R9 page-end read", w, 32'hC7C6_C5C4);
        wr(5'd0, 32'h3);
        n0 = op_n;
        wr(5'd1, ctrl(15, 0, 1'b1));
        wait_end(s);
        check(s[1:0] == 2'b10, "R9 cross sets error", s, 32'hA);
        check(op_n == n0, "R9 no frame", 32'(op_n - n0), 32'd0);
        wr(5'd0, 32'h0);
        rd(5'd0, s);
        check(s[1] == 1'b1, "R8 zero write keeps error", s, 32'hA);
        wr(5'd0, 32'h2);
        rd(5'd0, s);
        check(s == 32'h8, "R8 error cleared", s, 32'h8);
        n0 = op_n;
        wr(5'd1, ctrl(0, 1, 1'b1));
        wait_end(s);
        check(s[1:0] == 2'b10 && op_n == n0, "R9 reserved code", s, 32'hA);
        wr(5'd0, 32'h3);
    endtask

    task automatic t_busy_go();
        logic [31:0] s, c;
        int n0;
        wr(5'd2, 32'h0000_0020);
        n0 = op_n;
        wr(5'd1, ctrl(3, 0, 1'b1));
        rd(5'd0, s);
        check(s[5] == 1'b1, "R10 in-progress bit", s, 32'h28);
        wr(5'd1, ctrl(5, 2, 1'b1));
        wait_end(s);
        rd(5'd1, c);
        check(c == 32'h0300, "R10 R12 ctrl unchanged", c, 32'h0300);
        check(op_n - n0 == 1 && op_log[n0[7:0]] == 8'h03, "R10 go ignored", 32'(op_n - n0), 32'd1);
        check(s[5] == 1'b0 && spi_cs_n && !spi_sck, "R11 idle after cycle", s, 32'h9);
        wr(5'd0, 32'h3);
    endtask

    task automatic t_erase();
        logic [31:0] s;
        int n0;
        wr(5'd2, 32'h0000_0000);
        n0 = op_n;
        wr(5'd1, ctrl(0, 3, 1'b1));
        wait_end(s);
        check(s[1:0] == 2'b01, "R7 erase done", s, 32'h9);
        check(op_log[n0[7:0]] == 8'h06 && op_log[8'(n0 + 1)] == 8'h20, "R6 erase opcodes",
              {op_log[n0[7:0]], op_log[8'(n0 + 1)]}, 32'h0620);
        check(op_n - n0 == 5, "R7 erase polls", 32'(op_n - n0), 32'd5);
        check(mem[16] == 8'hFF && mem[256] == 8'hFF, "R6 erased", {mem[16], mem[256]}, 32'hFFFF);
        wr(5'd0, 32'h3);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'hFF;
        for (int i = 0; i < 64; i++)   mem[256 + i] = 8'(i) ^ 8'h5A;
        for (int i = 0; i < 8; i++)    mem[248 + i] = 8'(8'hC0 + i);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_addr();
        t_ctrl_readback();
        t_program();
        t_w1c();
        t_read_small();
        t_read_full();
        t_page_edge();
        t_busy_go();
        t_erase();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule